// File: doc/BRIEF.md
# Free-Running Event Counter with Global Timer Control

This block holds the shared state of a multi-channel event timer: an up-counter that advances once per clock, a global run switch, a switch that selects the fixed legacy interrupt mapping, and a per-channel pending-status word. Software reaches these through a simple 64-bit register port. A register is read combinationally while `reg_sel` is high and `reg_we` is low. A write takes effect at the clock edge where `reg_sel` and `reg_we` are both high.

The comparator channels sit outside this block. They receive the counter value and the run switch from it. Each channel reports a match back as a one-cycle pulse on `ch_hit`. It also gives its trigger style on `ch_level`, where 1 means level mode and 0 means edge mode. Only level-mode channels keep a pending bit here, and software clears that bit by writing a one to it.

A build parameter selects the counter width. A 32-bit build wraps at 2^32, and the upper half of its counter always reads as zero.

Top module: `evt_timer_core`

## Requirements
- R1: After reset, the configuration register, the status word and the counter all read as zero.
- R2: Offset 0x000 returns a read-only capability word, and writes to it have no effect. Its fields are:
  - [63:32] tick period in femtoseconds;
  - [31:16] vendor code;
  - [15] legacy mapping supported;
  - [14] zero;
  - [13] 1 when the counter is 64 bits wide;
  - [12:8] channel count minus one;
  - [7:0] revision.
- R3: The register offsets are 0x010 for configuration, 0x020 for status and 0x0F0 for the counter. Any other offset reads as zero.
- R4: In the configuration register, bit 0 is the run switch and bit 1 is the legacy-mapping switch. Both are shown on `run_en` and `legacy_en`. All other configuration bits read as zero.
- R5: While the run switch is 1, the counter rises by exactly one per clock. While it is 0, the counter holds its value. `cnt_val` always equals the counter register.
- R6: A write to the counter offset loads the counter only while the run switch is 0. At any other time the write is ignored.
- R7: In a 32-bit build, bits 63:32 of the counter always read as zero, and the counter wraps from 0xFFFFFFFF to 0.
- R8: Status bit n (read at offset 0x020) is set by a `ch_hit[n]` pulse when `ch_level[n]` is 1. It stays set until it is cleared. A bit whose channel is in edge mode reads as zero.
- R9: Writing a 1 to a status bit clears that bit. Writing a 0 leaves it unchanged.
- R10: If a set pulse and a clearing write reach the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` |
| ch_hit | input | NUM_CH | Per-channel status-set pulses |
| ch_level | input | NUM_CH | Per-channel trigger style, 1 = level |
| cnt_val | output | 64 | Counter value exported to the channels |
| run_en | output | 1 | Global run switch |
| legacy_en | output | 1 | Legacy mapping switch |

## Verification
The bench builds two instances on one shared register port.

- A 64-bit instance with three channels. It is preloaded just below a 2^32 boundary, which shows that its carry passes into the upper word.
- A 32-bit instance with four channels. Loaded with the same value, it shows the counter truncated, wrapping to zero and reading zeros in its upper half.

Each instance gets its own mix of level-mode and edge-mode channels. This lets a single set or clear operation produce different status results in the two instances, including the case where a set pulse and a clearing write hit the same bit in the same cycle.

// File: rtl/evt_timer_core.sv
module evt_timer_core #(
  parameter int          NUM_CH    = 3,
  parameter bit          CNT64     = 1'b1,
  parameter bit          LEGACY_OK = 1'b1,
  parameter logic [31:0] PERIOD_FS = 32'd10_000_000,
  parameter logic [15:0] VENDOR    = 16'hA5C3,
  parameter logic [7:0]  REV       = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [11:0]       reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  input  logic [NUM_CH-1:0] ch_hit,
  input  logic [NUM_CH-1:0] ch_level,
  output logic [63:0]       cnt_val,
  output logic              run_en,
  output logic              legacy_en
);
  localparam int CW = CNT64 ? 64 : 32;
  localparam logic [11:0] OFS_CAP = 12'h000;
  localparam logic [11:0] OFS_CFG = 12'h010;
  localparam logic [11:0] OFS_STS = 12'h020;
  localparam logic [11:0] OFS_CNT = 12'h0F0;
  localparam logic [4:0]  CH_M1   = 5'(NUM_CH - 1);
  localparam logic [63:0] CAP_WORD =
    {PERIOD_FS, VENDOR, LEGACY_OK, 1'b0, CNT64, CH_M1, REV};

  logic [CW-1:0]     cnt_q;
  logic [NUM_CH-1:0] sts_q, sts_d, clr_mask;
  logic              en_q, leg_q;

  wire wr     = reg_sel & reg_we;
  wire wr_cfg = wr && (reg_addr == OFS_CFG);
  wire wr_sts = wr && (reg_addr == OFS_STS);
  wire wr_cnt = wr && (reg_addr == OFS_CNT);

  assign clr_mask = wr_sts ? reg_wdata[NUM_CH-1:0] : '0;
  assign sts_d    = ((sts_q & ~clr_mask) | (ch_hit & ch_level)) & ch_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      leg_q <= 1'b0;
    end else if (wr_cfg) begin
      en_q  <= reg_wdata[0];
      leg_q <= reg_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (wr_cnt && !en_q) cnt_q <= reg_wdata[CW-1:0];
    else if (en_q)            cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  assign cnt_val   = 64'(cnt_q);
  assign run_en    = en_q;
  assign legacy_en = leg_q;

  always_comb begin
    case (reg_addr)
      OFS_CAP: reg_rdata = CAP_WORD;
      OFS_CFG: reg_rdata = {62'd0, leg_q, en_q};
      OFS_STS: reg_rdata = 64'(sts_q);
      OFS_CNT: reg_rdata = cnt_val;
      default: reg_rdata = '0;
    endcase
  end
endmodule

module evt_timer_core_chk #(
  parameter int NUM_CH = 3,
  parameter bit CNT64  = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_sel,
  input logic              reg_we,
  input logic [11:0]       reg_addr,
  input logic [63:0]       reg_wdata,
  input logic [NUM_CH-1:0] ch_hit,
  input logic [NUM_CH-1:0] ch_level,
  input logic [63:0]       cnt_val,
  input logic              run_en,
  input logic [NUM_CH-1:0] sts_q
);
  wire cnt_wr = reg_sel && reg_we && (reg_addr == 12'h0F0);
  wire sts_wr = reg_sel && reg_we && (reg_addr == 12'h020);
  wire [NUM_CH-1:0] lvl_hit = ch_hit & ch_level;

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !cnt_wr) |=> $stable(cnt_val)); // R5
  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> (CNT64 ? (cnt_val == $past(cnt_val) + 64'd1)
                      : (cnt_val[31:0] == $past(cnt_val[31:0]) + 32'd1))); // R5
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !CNT64 |-> (cnt_val[63:32] == 32'd0)); // R7
  AST_EDGE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & ~$past(ch_level)) == '0)); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|lvl_hit) |=> ((sts_q & $past(lvl_hit)) == $past(lvl_hit))); // R10
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && (lvl_hit == '0)) |=> ((sts_q & $past(reg_wdata[NUM_CH-1:0])) == '0)); // R9
  AST_W0_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && (lvl_hit == '0)) |=>
      ((sts_q & ~$past(reg_wdata[NUM_CH-1:0])) == ($past(sts_q) & ~$past(reg_wdata[NUM_CH-1:0]) & $past(ch_level)))); // R9
endmodule

bind evt_timer_core evt_timer_core_chk #(.NUM_CH(NUM_CH), .CNT64(CNT64)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ch_hit(ch_hit),
  .ch_level(ch_level), .cnt_val(cnt_val), .run_en(run_en), .sts_q(sts_q)
);

// File: tb/evt_timer_core_tb_top.sv
module evt_timer_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [2:0] hit_a = '0;
  logic [3:0] hit_b = '0;
  logic [2:0] lvl_a = 3'b101;
  logic [3:0] lvl_b = 4'b0110;
  logic [63:0] rd_a, rd_b, cnt_a, cnt_b;
  logic run_a, run_b, leg_a, leg_b;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [63:0] qa[$], qb[$];
  string qt[$];

  always #4 clk = ~clk;

  evt_timer_core #(.NUM_CH(3), .CNT64(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(sel), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rd_a), .ch_hit(hit_a), .ch_level(lvl_a),
    .cnt_val(cnt_a), .run_en(run_a), .legacy_en(leg_a));

  evt_timer_core #(.NUM_CH(4), .CNT64(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .reg_sel(sel), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rd_b), .ch_hit(hit_b), .ch_level(lvl_b),
    .cnt_val(cnt_b), .run_en(run_b), .legacy_en(leg_b));

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #2;
    if (sel && !we) begin
      if (qt.size() == 0) chk(1, 0, "scoreboard empty");
      else begin
        string t;
        logic [63:0] ea, eb;
        ea = qa.pop_front(); eb = qb.pop_front(); t = qt.pop_front();
        chk(rd_a, ea, {t, " (64-bit)"});
        chk(rd_b, eb, {t, " (32-bit)"});
      end
    end
  end

  task automatic rd(input logic [11:0] a, input logic [63:0] ea, input logic [63:0] eb, input string t);
    sel = 1'b1; we = 1'b0; addr = a;
    qa.push_back(ea); qb.push_back(eb); qt.push_back(t);
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic wr_hit(input logic [11:0] a, input logic [63:0] d, input logic [2:0] ha, input logic [3:0] hb);
    hit_a = ha; hit_b = hb;
    wr(a, d);
    hit_a = '0; hit_b = '0;
  endtask

  task automatic pulse(input logic [2:0] ha, input logic [3:0] hb);
    hit_a = ha; hit_b = hb;
    @(negedge clk);
    hit_a = '0; hit_b = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [63:0] CAP_A = {32'd10_000_000, 16'hA5C3, 1'b1, 1'b0, 1'b1, 5'd2, 8'h03};
  localparam logic [63:0] CAP_B = {32'd10_000_000, 16'hA5C3, 1'b1, 1'b0, 1'b0, 5'd3, 8'h03};

  initial begin
    idle(3);
    rst_n = 1'b1;
    rd(12'h000, CAP_A, CAP_B, "R2 capability word");
    rd(12'h010, 0, 0, "R1 config after reset");
    rd(12'h020, 0, 0, "R1 status after reset");
    rd(12'h0F0, 0, 0, "R1 counter after reset");

    wr(12'h0F0, 64'h0000_0001_FFFF_FFF0);
    rd(12'h0F0, 64'h1_FFFF_FFF0, 64'hFFFF_FFF0, "R6 R7 load while stopped");
    idle(2);
    rd(12'h0F0, 64'h1_FFFF_FFF0, 64'hFFFF_FFF0, "R5 hold while stopped");

    wr(12'h010, 64'h3);
    #1;
    chk({63'd0, run_a}, 1, "R4 run_en set");
    chk({63'd0, leg_b}, 1, "R4 legacy_en set");
    @(negedge clk);
    idle(2);
    rd(12'h0F0, 64'h1_FFFF_FFF3, 64'hFFFF_FFF3, "R5 count +3");
    idle(12);
    rd(12'h0F0, 64'h2_0000_0000, 64'h0, "R5 R7 carry and wrap");
    wr(12'h0F0, 64'h55);
    rd(12'h0F0, 64'h2_0000_0002, 64'h2, "R6 write ignored while running");
    wr(12'h010, 64'h0);
    rd(12'h0F0, 64'h2_0000_0004, 64'h4, "R5 stop");
    #1;
    chk({63'd0, run_a}, 0, "R4 run_en cleared");
    chk({63'd0, leg_a}, 0, "R4 legacy_en cleared");
    chk(cnt_a, 64'h2_0000_0004, "R5 cnt_val port");
    chk(cnt_b, 64'h4, "R7 cnt_val port 32-bit");
    @(negedge clk);
    idle(3);
    rd(12'h0F0, 64'h2_0000_0004, 64'h4, "R5 hold after stop");

    wr(12'h010, 64'hFFFF_FFFF_FFFF_FFF2);
    rd(12'h010, 64'h2, 64'h2, "R4 only two config bits");
    rd(12'h0F0, 64'h2_0000_0004, 64'h4, "R4 counter still stopped");

    wr(12'h000, 64'h0);
    rd(12'h000, CAP_A, CAP_B, "R2 capability read-only");
    rd(12'h030, 0, 0, "R3 unmapped offset");
    rd(12'h0F8, 0, 0, "R3 unmapped offset near counter");

    pulse(3'b111, 4'b1111);
    rd(12'h020, 64'h5, 64'h6, "R8 level bits latch, edge bits zero");
    wr(12'h020, 64'h1);
    rd(12'h020, 64'h4, 64'h6, "R9 write one clears");
    wr(12'h020, 64'h0);
    rd(12'h020, 64'h4, 64'h6, "R9 write zero no effect");
    wr_hit(12'h020, 64'hFFFF_FFFF_FFFF_FFFF, 3'b100, 4'b0010);
    rd(12'h020, 64'h4, 64'h2, "R10 set beats clear");
    wr(12'h020, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(12'h020, 64'h0, 64'h0, "R9 clear all");

    idle(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule